// File: doc/BRIEF.md
# Machine Trap Register Unit

This block keeps the machine-level trap state of a small processor core: the global interrupt enable and its saved copy, the per-line interrupt enables, the pending view of the interrupt lines, the handler base address with its dispatch mode, the saved exception PC, the trap cause and a scratch word. Software reaches these registers through a single-cycle register port that takes a 12-bit address. An access to an address the block does not hold raises an illegal-access flag in the same cycle.

The pipeline signals a trap with the faulting PC, a 5-bit cause code and an interrupt flag. In that same cycle the block returns the handler address, and at the clock edge it saves the trap state. A return-from-trap strobe restores the interrupt enable. The exception PC is always presented as the return target. The block also provides the global enable and the vector of interrupts that are both pending and enabled. Choosing one interrupt from that vector is left to the caller.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset, status (0x300) reads 0x0000_1800, the vector register (0x305) reads {base_in[31:8], 8'h01}, and enable, exception PC, cause and scratch all read 0.
- R2: Status (0x300) stores only bit 7 (saved enable) and bit 3 (enable). Bits 12:11 always read 11, and every other bit reads 0 whatever is written.
- R3: On trap entry, bit 7 takes the old bit 3 and bit 3 clears. On a return strobe without a trap, bit 3 takes bit 7 and bit 7 sets. A trap in the same cycle as a return acts as a trap only.
- R4: Enable (0x304) stores only bits 31:16, 11, 7 and 3, and all other bits read 0. Pending (0x344) reads the interrupt input masked to those same bits, and writes to it have no effect. The active-interrupt output equals pending AND enable in the same cycle.
- R5: The vector register (0x305) stores bits 31:8 and bit 0, and bits 7:1 read 0. Bit 0 = 0 selects direct mode and bit 0 = 1 selects vectored mode.
- R6: The exception PC (0x341) holds bit 0 at 0. It captures the trap PC on trap entry, and it drives the return-PC output.
- R7: Cause (0x342) stores bit 31 (interrupt flag) and bits 4:0 (code), and bits 30:5 read 0. On trap entry it loads {interrupt flag, code}. Scratch (0x340) stores all 32 bits.
- R8: During a trap cycle the handler address is {vector[31:8], 8'h00}. When the trap is an interrupt and vectored mode is on, 4 × code is added to it.
- R9: A trap entry in the same cycle as a software write to status, exception PC or cause wins, and the write is lost.
- R10: An access to any address other than the seven listed raises the illegal flag in the same cycle and changes no register.
- R11: The global-enable output equals status bit 3, and software writes to it take effect in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_base_i | input | 32 | Handler base loaded at reset (bits 31:8 used) |
| csr_access_i | input | 1 | Register port access strobe |
| csr_write_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data (combinational) |
| csr_illegal_o | output | 1 | Access to an unimplemented address |
| trap_i | input | 1 | Trap entry strobe |
| trap_pc_i | input | 32 | PC saved on trap entry |
| trap_code_i | input | 5 | Cause code of the trap |
| trap_irq_i | input | 1 | Trap is an interrupt |
| mret_i | input | 1 | Return-from-trap strobe |
| irq_i | input | 32 | Interrupt lines |
| handler_pc_o | output | 32 | Handler address for the current trap |
| return_pc_o | output | 32 | Saved exception PC |
| gie_o | output | 1 | Global interrupt enable |
| irq_active_o | output | 32 | Pending and enabled interrupts |

## Verification
The handler address, the illegal flag, read data, the active-interrupt vector and the global enable are combinational. The bench drives stimulus just after a falling edge and samples these outputs 1 ns later, before the next rising edge. Register updates from writes, trap entry and return land on the rising edge and are first visible in the following cycle. The bench therefore checks them with reads issued in later cycles against a model it updates at that same edge. The checker confirms the one-cycle effects of trap entry and return with properties that look one cycle ahead.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

   localparam logic [11:0] ADDR_STATUS  = 12'h300;
   localparam logic [11:0] ADDR_ENABLE  = 12'h304;
   localparam logic [11:0] ADDR_VECTOR  = 12'h305;
   localparam logic [11:0] ADDR_SCRATCH = 12'h340;
   localparam logic [11:0] ADDR_EPC     = 12'h341;
   localparam logic [11:0] ADDR_CAUSE   = 12'h342;
   localparam logic [11:0] ADDR_PENDING = 12'h344;

   localparam int unsigned IE_POS  = 3;
   localparam int unsigned PIE_POS = 7;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ENABLE,
      SEL_VECTOR,
      SEL_SCRATCH,
      SEL_EPC,
      SEL_CAUSE,
      SEL_PENDING
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [11:0] addr);
      case (addr)
         ADDR_STATUS:  return SEL_STATUS;
         ADDR_ENABLE:  return SEL_ENABLE;
         ADDR_VECTOR:  return SEL_VECTOR;
         ADDR_SCRATCH: return SEL_SCRATCH;
         ADDR_EPC:     return SEL_EPC;
         ADDR_CAUSE:   return SEL_CAUSE;
         ADDR_PENDING: return SEL_PENDING;
         default:      return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/mtrap_status.sv
module mtrap_status (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_en_i,
   input  logic wr_ie_i,
   input  logic wr_pie_i,
   input  logic trap_i,
   input  logic mret_i,
   output logic ie_o,
   output logic pie_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ie_o  <= 1'b0;
         pie_o <= 1'b0;
      end else if (trap_i) begin
         pie_o <= ie_o;
         ie_o  <= 1'b0;
      end else if (mret_i) begin
         ie_o  <= pie_o;
         pie_o <= 1'b1;
      end else if (wr_en_i) begin
         ie_o  <= wr_ie_i;
         pie_o <= wr_pie_i;
      end
   end
endmodule

// File: rtl/mtrap_irq.sv
module mtrap_irq #(
   parameter int unsigned           W    = 32,
   parameter logic [W-1:0]          MASK = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] irq_i,
   output logic [W-1:0] enable_o,
   output logic [W-1:0] pending_o,
   output logic [W-1:0] active_o
);
   if (MASK == '0) begin : g_bad_mask
      $error("mtrap_irq: MASK selects no interrupt line");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      enable_o <= '0;
      else if (wr_en_i) enable_o <= wdata_i & MASK;
   end

   assign pending_o = irq_i & MASK;
   assign active_o  = pending_o & enable_o;
endmodule

// File: rtl/mtrap_vector.sv
module mtrap_vector #(
   parameter int unsigned W      = 32,
   parameter int unsigned ALIGN  = 8,
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [W-1:0]      boot_base_i,
   input  logic              wr_en_i,
   input  logic [W-1:0]      wdata_i,
   input  logic              irq_trap_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [W-1:0]      vector_o,
   output logic [W-1:0]      target_o
);
   localparam logic [W-1:0] BASE_MASK = {W{1'b1}} << ALIGN;

   if (CODE_W + 2 > ALIGN) begin : g_bad_align
      $error("mtrap_vector: vector table would overlap the base alignment");
   end
   if (ALIGN >= W) begin : g_bad_width
      $error("mtrap_vector: alignment exceeds the word width");
   end

   logic [W-1:0] base_q;
   logic         mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= boot_base_i & BASE_MASK;
         mode_q <= 1'b1;
      end else if (wr_en_i) begin
         base_q <= wdata_i & BASE_MASK;
         mode_q <= wdata_i[0];
      end
   end

   logic [W-1:0] offset;
   assign offset   = (mode_q && irq_trap_i) ? W'({code_i, 2'b00}) : '0;
   assign vector_o = base_q | W'(mode_q);
   assign target_o = base_q + offset;
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 5,
   parameter int unsigned TVEC_ALIGN  = 8,
   parameter int unsigned FAST_IRQ_LO = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [XLEN-1:0]    boot_base_i,
   input  logic               csr_access_i,
   input  logic               csr_write_i,
   input  logic [11:0]        csr_addr_i,
   input  logic [XLEN-1:0]    csr_wdata_i,
   output logic [XLEN-1:0]    csr_rdata_o,
   output logic               csr_illegal_o,
   input  logic               trap_i,
   input  logic [XLEN-1:0]    trap_pc_i,
   input  logic [CAUSE_W-1:0] trap_code_i,
   input  logic               trap_irq_i,
   input  logic               mret_i,
   input  logic [XLEN-1:0]    irq_i,
   output logic [XLEN-1:0]    handler_pc_o,
   output logic [XLEN-1:0]    return_pc_o,
   output logic               gie_o,
   output logic [XLEN-1:0]    irq_active_o
);
   import mtrap_pkg::*;

   localparam logic [XLEN-1:0] IRQ_MASK =
      ({XLEN{1'b1}} << FAST_IRQ_LO) | XLEN'(32'h0000_0888);
   localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

   if (XLEN < 16) begin : g_bad_xlen
      $error("mtrap_csr_unit: XLEN too small for the status layout");
   end
   if (FAST_IRQ_LO < 12 || FAST_IRQ_LO >= XLEN) begin : g_bad_fast
      $error("mtrap_csr_unit: FAST_IRQ_LO out of range");
   end
   if (CAUSE_W >= XLEN - 1) begin : g_bad_cause
      $error("mtrap_csr_unit: cause code overlaps the interrupt flag");
   end

   reg_sel_e sel;
   logic     wr;
   assign sel           = decode_addr(csr_addr_i);
   assign csr_illegal_o = csr_access_i && (sel == SEL_NONE);
   assign wr            = csr_access_i && csr_write_i && (sel != SEL_NONE);

   // status
   logic st_ie, st_pie;
   mtrap_status u_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr && sel == SEL_STATUS),
      .wr_ie_i  (csr_wdata_i[IE_POS]),
      .wr_pie_i (csr_wdata_i[PIE_POS]),
      .trap_i   (trap_i),
      .mret_i   (mret_i),
      .ie_o     (st_ie),
      .pie_o    (st_pie)
   );
   assign gie_o = st_ie;

   // interrupt enable / pending
   logic [XLEN-1:0] ie_q, ip_w;
   mtrap_irq #(.W(XLEN), .MASK(IRQ_MASK)) u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr && sel == SEL_ENABLE),
      .wdata_i   (csr_wdata_i),
      .irq_i     (irq_i),
      .enable_o  (ie_q),
      .pending_o (ip_w),
      .active_o  (irq_active_o)
   );

   // trap vector
   logic [XLEN-1:0] tvec_q;
   mtrap_vector #(.W(XLEN), .ALIGN(TVEC_ALIGN), .CODE_W(CAUSE_W)) u_vector (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .boot_base_i (boot_base_i),
      .wr_en_i     (wr && sel == SEL_VECTOR),
      .wdata_i     (csr_wdata_i),
      .irq_trap_i  (trap_irq_i),
      .code_i      (trap_code_i),
      .vector_o    (tvec_q),
      .target_o    (handler_pc_o)
   );

   // exception PC, cause, scratch
   logic [XLEN-1:0]    epc_q, scratch_q;
   logic               cause_irq_q;
   logic [CAUSE_W-1:0] cause_code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         epc_q        <= '0;
         cause_irq_q  <= 1'b0;
         cause_code_q <= '0;
      end else if (trap_i) begin
         epc_q        <= trap_pc_i & EVEN_MASK;
         cause_irq_q  <= trap_irq_i;
         cause_code_q <= trap_code_i;
      end else if (wr && sel == SEL_EPC) begin
         epc_q        <= csr_wdata_i & EVEN_MASK;
      end else if (wr && sel == SEL_CAUSE) begin
         cause_irq_q  <= csr_wdata_i[XLEN-1];
         cause_code_q <= csr_wdata_i[CAUSE_W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      scratch_q <= '0;
      else if (wr && sel == SEL_SCRATCH) scratch_q <= csr_wdata_i;
   end

   assign return_pc_o = epc_q;

   always_comb begin
      csr_rdata_o = '0;
      case (sel)
         SEL_STATUS: begin
            csr_rdata_o[12:11]   = 2'b11;
            csr_rdata_o[PIE_POS] = st_pie;
            csr_rdata_o[IE_POS]  = st_ie;
         end
         SEL_ENABLE:  csr_rdata_o = ie_q;
         SEL_VECTOR:  csr_rdata_o = tvec_q;
         SEL_SCRATCH: csr_rdata_o = scratch_q;
         SEL_EPC:     csr_rdata_o = epc_q;
         SEL_CAUSE: begin
            csr_rdata_o[XLEN-1]      = cause_irq_q;
            csr_rdata_o[CAUSE_W-1:0] = cause_code_q;
         end
         SEL_PENDING: csr_rdata_o = ip_w;
         default:     csr_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/mtrap_csr_unit_chk.sv
module mtrap_csr_unit_chk #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned TVEC_ALIGN = 8
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            csr_access_i,
   input logic            csr_write_i,
   input logic [11:0]     csr_addr_i,
   input logic            csr_illegal_o,
   input logic            trap_i,
   input logic [XLEN-1:0] trap_pc_i,
   input logic            trap_irq_i,
   input logic            mret_i,
   input logic [XLEN-1:0] irq_i,
   input logic [XLEN-1:0] handler_pc_o,
   input logic [XLEN-1:0] return_pc_o,
   input logic            gie_o,
   input logic [XLEN-1:0] irq_active_o,
   input logic            st_pie,
   input logic            tvec_mode
);
   p_trap_clears_ie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_i |=> !gie_o);

   p_trap_saves_ie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_i |=> (st_pie == $past(gie_o)));

   p_mret_restores_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mret_i && !trap_i) |=> (gie_o == $past(st_pie)));

   p_epc_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_i |=> (return_pc_o == ($past(trap_pc_i) & ~XLEN'(1))));

   p_active_subset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_active_o & ~irq_i) == '0));

   p_illegal_needs_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csr_illegal_o |-> csr_access_i);

   p_handler_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_i && !(tvec_mode && trap_irq_i)) |-> (handler_pc_o[TVEC_ALIGN-1:0] == '0));

   p_gie_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trap_i && !mret_i && !(csr_access_i && csr_write_i && csr_addr_i == 12'h300))
      |=> $stable(gie_o));
endmodule

bind mtrap_csr_unit mtrap_csr_unit_chk #(.XLEN(XLEN), .TVEC_ALIGN(TVEC_ALIGN)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .csr_access_i  (csr_access_i),
   .csr_write_i   (csr_write_i),
   .csr_addr_i    (csr_addr_i),
   .csr_illegal_o (csr_illegal_o),
   .trap_i        (trap_i),
   .trap_pc_i     (trap_pc_i),
   .trap_irq_i    (trap_irq_i),
   .mret_i        (mret_i),
   .irq_i         (irq_i),
   .handler_pc_o  (handler_pc_o),
   .return_pc_o   (return_pc_o),
   .gie_o         (gie_o),
   .irq_active_o  (irq_active_o),
   .st_pie        (st_pie),
   .tvec_mode     (tvec_q[0])
);

// File: tb/mtrap_csr_unit_tb.sv
module mtrap_csr_unit_tb;
   localparam logic [31:0] MASK = 32'hFFFF_0888;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] boot_base = 32'h8000_1234;
   logic        acc = 0, wr = 0, trap = 0, tirq = 0, mret = 0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0, tpc = '0, irq = '0;
   logic [4:0]  tcode = '0;
   logic [31:0] rdata, handler, retpc, active;
   logic        illegal, gie;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   // model state
   bit          m_ie, m_pie, m_mode, m_cirq;
   logic [31:0] m_en, m_base, m_epc, m_scr;
   logic [4:0]  m_code;

   always #4 clk = ~clk;

   mtrap_csr_unit u_dut (
      .clk_i(clk), .rst_ni(rst_n), .boot_base_i(boot_base),
      .csr_access_i(acc), .csr_write_i(wr), .csr_addr_i(addr),
      .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_illegal_o(illegal),
      .trap_i(trap), .trap_pc_i(tpc), .trap_code_i(tcode), .trap_irq_i(tirq),
      .mret_i(mret), .irq_i(irq), .handler_pc_o(handler),
      .return_pc_o(retpc), .gie_o(gie), .irq_active_o(active)
   );

   function automatic bit is_legal(logic [11:0] a);
      return a == 12'h300 || a == 12'h304 || a == 12'h305 || a == 12'h340 ||
             a == 12'h341 || a == 12'h342 || a == 12'h344;
   endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a);
      case (a)
         12'h300: return 32'h1800 | (32'(m_pie) << 7) | (32'(m_ie) << 3);
         12'h304: return m_en;
         12'h305: return m_base | 32'(m_mode);
         12'h340: return m_scr;
         12'h341: return m_epc;
         12'h342: return {m_cirq, 26'b0, m_code};
         12'h344: return irq & MASK;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_handler(bit is_irq, logic [4:0] code);
      return m_base + ((m_mode && is_irq) ? {25'b0, code, 2'b00} : 32'h0);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ie = 0; m_pie = 0; m_mode = 1; m_cirq = 0; m_code = '0;
      m_en = '0; m_base = boot_base & 32'hFFFF_FF00; m_epc = '0; m_scr = '0;
   endtask

   task automatic model_edge(bit a_acc, bit a_wr, logic [11:0] a, logic [31:0] d,
                             bit tr, logic [31:0] pc, logic [4:0] code, bit ti, bit mr);
      bit w = a_acc && a_wr && is_legal(a);
      if (tr) begin m_pie = m_ie; m_ie = 0; end
      else if (mr) begin m_ie = m_pie; m_pie = 1; end
      else if (w && a == 12'h300) begin m_ie = d[3]; m_pie = d[7]; end
      if (tr) begin m_epc = pc & ~32'h1; m_cirq = ti; m_code = code; end
      else if (w && a == 12'h341) m_epc = d & ~32'h1;
      else if (w && a == 12'h342) begin m_cirq = d[31]; m_code = d[4:0]; end
      if (w && a == 12'h304) m_en = d & MASK;
      if (w && a == 12'h305) begin m_base = d & 32'hFFFF_FF00; m_mode = d[0]; end
      if (w && a == 12'h340) m_scr = d;
   endtask

   // one clocked operation; handler (R8) and illegal flag (R10) checked before the edge
   task automatic step(bit a_acc, bit a_wr, logic [11:0] a, logic [31:0] d,
                       bit tr, logic [31:0] pc, logic [4:0] code, bit ti, bit mr);
      @(negedge clk);
      acc = a_acc; wr = a_wr; addr = a; wdata = d;
      trap = tr; tpc = pc; tcode = code; tirq = ti; mret = mr;
      #1;
      if (tr) chk("R8 handler", handler, exp_handler(ti, code));
      chk("R10 illegal", 32'(illegal), 32'(a_acc && !is_legal(a)));
      @(posedge clk);
      model_edge(a_acc, a_wr, a, d, tr, pc, code, ti, mr);
      #1;
      acc = 0; wr = 0; trap = 0; mret = 0;
   endtask

   task automatic rd(logic [11:0] a, string req);
      @(negedge clk);
      acc = 1; wr = 0; addr = a;
      #1;
      chk(req, rdata, exp_read(a));
      acc = 0;
   endtask

   task automatic check_all();
      rd(12'h300, "R2 status");
      rd(12'h304, "R4 enable");
      rd(12'h305, "R5 vector");
      rd(12'h340, "R7 scratch");
      rd(12'h341, "R6 epc");
      rd(12'h342, "R7 cause");
      rd(12'h344, "R4 pending");
      chk("R11 gie", 32'(gie), 32'(m_ie));
      chk("R6 return pc", retpc, m_epc);
      chk("R4 active", active, irq & MASK & m_en);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      rd(12'h300, "R1 status reset");
      rd(12'h305, "R1 vector reset");
      chk("R1 vector value", exp_read(12'h305), 32'h8000_1201);
      rd(12'h304, "R1 enable reset");
      rd(12'h341, "R1 epc reset");
      rd(12'h342, "R1 cause reset");
      rd(12'h340, "R1 scratch reset");
      chk("R11 gie reset", 32'(gie), 32'h0);

      // R2 / R11 status write masking
      step(1, 1, 12'h300, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      rd(12'h300, "R2 status all ones");
      chk("R2 status value", exp_read(12'h300), 32'h0000_1888);
      chk("R11 gie after write", 32'(gie), 32'h1);

      // R5 vector write masking
      step(1, 1, 12'h305, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      rd(12'h305, "R5 vector all ones");

      // R4 enable/pending, pending not writable
      step(1, 1, 12'h304, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      irq = 32'hFFFF_FFFF;
      rd(12'h304, "R4 enable mask");
      step(1, 1, 12'h344, 32'h0, 0, 0, 0, 0, 0);
      rd(12'h344, "R4 pending write ignored");
      chk("R4 active all", active, 32'hFFFF_0888);
      irq = 32'h0001_0008;
      #1 chk("R4 active follows input", active, 32'h0001_0008);

      // R6 epc bit 0
      step(1, 1, 12'h341, 32'h0000_1235, 0, 0, 0, 0, 0);
      rd(12'h341, "R6 epc bit0");

      // R10 illegal access leaves state untouched
      step(1, 1, 12'h343, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
      step(1, 0, 12'hF14, 32'h0, 0, 0, 0, 0, 0);
      check_all();

      // R8 direct mode, then R3/R6/R7 trap capture
      step(1, 1, 12'h305, 32'h2000_0000, 0, 0, 0, 0, 0);
      step(1, 1, 12'h300, 32'h0000_0008, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 32'h0000_0101, 5'd7, 1, 0);
      rd(12'h300, "R3 trap saves enable");
      rd(12'h342, "R7 trap cause");
      chk("R6 return after trap", retpc, 32'h0000_0100);

      // R3 return restores enable
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
      rd(12'h300, "R3 return restores");

      // R8 vectored mode: interrupt offsets, exception does not
      step(1, 1, 12'h305, 32'h2000_0001, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 32'h400, 5'd11, 1, 0);
      step(0, 0, 0, 0, 1, 32'h404, 5'd2, 0, 0);
      step(0, 0, 0, 0, 1, 32'h408, 5'd31, 1, 0);

      // R9 trap wins over same-cycle writes; R3 trap wins over return
      step(1, 1, 12'h341, 32'h000A_AAA0, 1, 32'h500, 5'd3, 0, 0);
      rd(12'h341, "R9 epc trap wins");
      step(1, 1, 12'h342, 32'h8000_001F, 1, 32'h504, 5'd4, 0, 0);
      rd(12'h342, "R9 cause trap wins");
      step(1, 1, 12'h300, 32'h0000_0088, 1, 32'h508, 5'd5, 0, 1);
      rd(12'h300, "R9 R3 status trap wins");

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [11:0] a;
         int sel = $urandom % 9;
         case (sel)
            0: a = 12'h300; 1: a = 12'h304; 2: a = 12'h305; 3: a = 12'h340;
            4: a = 12'h341; 5: a = 12'h342; 6: a = 12'h344; 7: a = 12'h343;
            default: a = 12'($urandom);
         endcase
         if ($urandom % 4 == 0) irq = $urandom;
         step(($urandom % 3) != 0, $urandom % 2, a, $urandom,
              ($urandom % 5) == 0, $urandom, 5'($urandom), $urandom % 2,
              ($urandom % 6) == 0);
         if (i % 10 == 0) check_all();
      end
      check_all();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule